// File: doc/BRIEF.md
# Endpoint Interrupt Dispatcher (MSI / INTx)

This block sits on the endpoint side of a PCIe function and turns software-visible mailbox events into host interrupts. A write into any mailbox word stores the data and raises the matching bit of a pending-status word. Software unmasks bits through a mask word and acknowledges serviced bits by writing ones to the status word. All three kinds of register are reached through one memory-mapped slave port with zero-wait reads.

The request is live while any unmasked status bit is set. It goes to the host by one of two routes. The choice follows two copied configuration-space controls: the MSI-enable bit and the legacy interrupt-disable bit. In MSI mode the block issues one posted memory write per rising edge of the live request, using the programmed message address and data. In legacy mode it drives a level request that follows the live request. Software may move between the two routes with an overlap in which both are enabled, and a request that is pending during the switch is carried across.

Top module: `hostIrqDispatch`

## Requirements
- R1: After reset the status word and mask word read as zero, `intxReq` is low and `mWrite` is low.
- R2: A slave write to word address 2+i (i below NUM_MBOX) stores the full data word in mailbox i, readable at the same address, and sets status bit i on the next clock.
- R3: The status word (address 0) is write-one-to-clear: each data bit written as 1 clears that status bit and bits written as 0 are left as they were. The mask word (address 1) is read/write in its low NUM_MBOX bits and reads zero above them.
- R4: A status bit whose mask bit is 0 causes neither `intxReq` nor an MSI write.
- R5: In legacy mode (MSI-enable 0, interrupt-disable 0), `intxReq` goes high on the clock after an unmasked status bit becomes set. It stays high while any unmasked bit remains set and goes low on the clock after the last one is cleared.
- R6: With MSI-enable 0 and interrupt-disable 1, no interrupt is sent and status is kept. Clearing interrupt-disable later raises `intxReq` on the next clock.
- R7: With MSI-enable 1, each rising edge of the live request gives exactly one accepted write, `mWrite` high on the next clock, `mAddr` equal to `msiAddr` and `mWriteData` equal to `msiData` zero-extended. `intxReq` stays low.
- R8: While `mWrite` is high and `mWaitReq` is high, `mWrite`, `mAddr` and `mWriteData` hold steady. After the cycle in which `mWaitReq` is low, `mWrite` drops unless a further write is owed.
- R9: When both MSI-enable is 1 and interrupt-disable is 0, the MSI route is used and `intxReq` stays low.
- R10: A request pending across a route change is delivered. Setting MSI-enable while legacy is active sends one MSI write and drops `intxReq`. Clearing MSI-enable while interrupt-disable is 0 raises `intxReq`.
- R11: A new rising edge of the live request that occurs while a write is still waiting is remembered, and a second write follows once the first is accepted.
- R12: Writes to addresses outside 0..NUM_MBOX+1 change nothing, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sAddr | input | ADDR_W | Slave word address |
| sWrite | input | 1 | Slave write strobe |
| sWriteData | input | DATA_W | Slave write data |
| sReadData | output | DATA_W | Slave read data, combinational from `sAddr` |
| cfgIntxDisable | input | 1 | Copy of the legacy interrupt-disable control |
| cfgMsiEnable | input | 1 | Copy of the MSI-enable control |
| msiAddr | input | MADDR_W | Programmed MSI message address |
| msiData | input | MSGDATA_W | Programmed MSI message data |
| mAddr | output | MADDR_W | Master write address |
| mWriteData | output | DATA_W | Master write data |
| mWrite | output | 1 | Master write request |
| mWaitReq | input | 1 | Master stall from the fabric |
| intxReq | output | 1 | Legacy level interrupt request |

## Verification
A vector table walks every combination of the two route controls against masked and unmasked mailbox bits. This separates legacy delivery, MSI delivery, the both-enabled overlap, the fully silenced state and masking. Directed runs add further cases. Several pending bits are cleared one at a time to show that the level holds until the last one goes. Each transition order is stepped through with a live request to show it survives. A write is stalled to check that the master holds its bus. A fall and re-rise of the request during a stall must yield a second write.

// File: rtl/irqDispPkg.sv
package irqDispPkg;

  localparam int REG_STATUS = 0;
  localparam int REG_MASK   = 1;
  localparam int MBOX_BASE  = 2;

  typedef struct packed {
    logic loadMsg;    // capture message address/data for a new write
    logic writeBusy;  // master write request is being presented
  } ctrlStrobe_t;

  typedef enum logic {
    MSI_IDLE = 1'b0,
    MSI_SEND = 1'b1
  } msiState_t;

endpackage

// File: rtl/irqDispDatapath.sv
module irqDispDatapath
  import irqDispPkg::*;
#(
  parameter int NUM_MBOX  = 8,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int MADDR_W   = 32,
  parameter int MSGDATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    sAddr,
  input  logic                 sWrite,
  input  logic [DATA_W-1:0]    sWriteData,
  output logic [DATA_W-1:0]    sReadData,
  input  logic [MADDR_W-1:0]   msiAddr,
  input  logic [MSGDATA_W-1:0] msiData,
  input  ctrlStrobe_t          strobe,
  output logic                 pendingAny,
  output logic [MADDR_W-1:0]   mAddr,
  output logic [DATA_W-1:0]    mWriteData
);

  localparam int MBOX_LAST = MBOX_BASE + NUM_MBOX - 1;

  logic [NUM_MBOX-1:0] statusQ;
  logic [NUM_MBOX-1:0] maskQ;
  logic [DATA_W-1:0]   mboxQ [NUM_MBOX];
  logic [NUM_MBOX-1:0] mboxSet;
  logic [NUM_MBOX-1:0] statusClr;
  logic                statusHit;
  logic                maskHit;

  assign statusHit = sWrite && (sAddr == ADDR_W'(REG_STATUS));
  assign maskHit   = sWrite && (sAddr == ADDR_W'(REG_MASK));
  assign statusClr = statusHit ? sWriteData[NUM_MBOX-1:0] : '0;

  for (genvar gi = 0; gi < NUM_MBOX; gi++) begin : g_mboxDecode
    assign mboxSet[gi] = sWrite && (sAddr == ADDR_W'(MBOX_BASE + gi));
  end

  // Status: set from mailbox writes has priority over write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
    end else begin
      statusQ <= (statusQ & ~statusClr) | mboxSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else if (maskHit) begin
      maskQ <= sWriteData[NUM_MBOX-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_MBOX; i++) mboxQ[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_MBOX; i++) begin
        if (mboxSet[i]) mboxQ[i] <= sWriteData;
      end
    end
  end

  assign pendingAny = |(statusQ & maskQ);

  always_comb begin
    sReadData = '0;
    if (sAddr == ADDR_W'(REG_STATUS)) begin
      sReadData = DATA_W'(statusQ);
    end else if (sAddr == ADDR_W'(REG_MASK)) begin
      sReadData = DATA_W'(maskQ);
    end else if (int'(sAddr) >= MBOX_BASE && int'(sAddr) <= MBOX_LAST) begin
      for (int i = 0; i < NUM_MBOX; i++) begin
        if (sAddr == ADDR_W'(MBOX_BASE + i)) sReadData = mboxQ[i];
      end
    end
  end

  // Message capture for the master port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAddr      <= '0;
      mWriteData <= '0;
    end else if (strobe.loadMsg) begin
      mAddr      <= msiAddr;
      mWriteData <= DATA_W'(msiData);
    end
  end

  AST_MBOX_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (|mboxSet) |=> ((statusQ & $past(mboxSet)) == $past(mboxSet))) // R2
    else $error("mailbox write did not set its status bit");

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (statusHit && !(|mboxSet)) |=> ((statusQ & $past(sWriteData[NUM_MBOX-1:0])) == '0)) // R3
    else $error("written-one status bit still set");

  AST_W1C_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    statusHit |=> ((statusQ & ~$past(sWriteData[NUM_MBOX-1:0])) == ($past(statusQ) & ~$past(sWriteData[NUM_MBOX-1:0])))) // R3
    else $error("status bit written as zero changed");

endmodule

// File: rtl/irqDispControl.sv
module irqDispControl
  import irqDispPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pendingAny,
  input  logic        cfgMsiEnable,
  input  logic        cfgIntxDisable,
  input  logic        mWaitReq,
  output ctrlStrobe_t strobe,
  output logic        mWrite,
  output logic        intxReq
);

  msiState_t stateQ, stateD;
  logic      msiMode;
  logic      intxMode;
  logic      msiLive;
  logic      msiLiveQ;
  logic      msiEdge;
  logic      owedQ;
  logic      launch;

  // MSI wins whenever it is enabled; legacy only when MSI is off and not disabled
  assign msiMode  = cfgMsiEnable;
  assign intxMode = !cfgMsiEnable && !cfgIntxDisable;

  assign msiLive = pendingAny && msiMode;
  assign msiEdge = msiLive && !msiLiveQ;
  assign launch  = (stateQ == MSI_IDLE) && msiMode && (owedQ || msiEdge);

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      MSI_IDLE: if (launch) stateD = MSI_SEND;
      MSI_SEND: if (!mWaitReq) stateD = MSI_IDLE;
      default:  stateD = MSI_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= MSI_IDLE;
      msiLiveQ <= 1'b0;
      owedQ    <= 1'b0;
      intxReq  <= 1'b0;
    end else begin
      stateQ   <= stateD;
      msiLiveQ <= msiLive;
      if (!msiMode || launch) begin
        owedQ <= 1'b0;
      end else if (msiEdge) begin
        owedQ <= 1'b1;
      end
      intxReq <= pendingAny && intxMode;
    end
  end

  assign mWrite           = (stateQ == MSI_SEND);
  assign strobe.loadMsg   = launch;
  assign strobe.writeBusy = mWrite;

  AST_INTX_ONLY_LEGACY: assert property (@(posedge clk) disable iff (!rstN)
    intxReq |-> $past(!cfgMsiEnable && !cfgIntxDisable)) // R6
    else $error("legacy request outside legacy mode");

  AST_MSI_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mWrite) |-> $past(cfgMsiEnable)) // R7
    else $error("MSI write started with MSI disabled");

  AST_INTX_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !pendingAny |=> !intxReq) // R5
    else $error("legacy request held with nothing pending");

endmodule

// File: rtl/hostIrqDispatch.sv
module hostIrqDispatch
  import irqDispPkg::*;
#(
  parameter int NUM_MBOX  = 8,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 32,
  parameter int MADDR_W   = 32,
  parameter int MSGDATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    sAddr,
  input  logic                 sWrite,
  input  logic [DATA_W-1:0]    sWriteData,
  output logic [DATA_W-1:0]    sReadData,
  input  logic                 cfgIntxDisable,
  input  logic                 cfgMsiEnable,
  input  logic [MADDR_W-1:0]   msiAddr,
  input  logic [MSGDATA_W-1:0] msiData,
  output logic [MADDR_W-1:0]   mAddr,
  output logic [DATA_W-1:0]    mWriteData,
  output logic                 mWrite,
  input  logic                 mWaitReq,
  output logic                 intxReq
);

  ctrlStrobe_t strobe;
  logic        pendingAny;

  irqDispDatapath #(
    .NUM_MBOX (NUM_MBOX),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MADDR_W  (MADDR_W),
    .MSGDATA_W(MSGDATA_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .sAddr     (sAddr),
    .sWrite    (sWrite),
    .sWriteData(sWriteData),
    .sReadData (sReadData),
    .msiAddr   (msiAddr),
    .msiData   (msiData),
    .strobe    (strobe),
    .pendingAny(pendingAny),
    .mAddr     (mAddr),
    .mWriteData(mWriteData)
  );

  irqDispControl i_control (
    .clk           (clk),
    .rstN          (rstN),
    .pendingAny    (pendingAny),
    .cfgMsiEnable  (cfgMsiEnable),
    .cfgIntxDisable(cfgIntxDisable),
    .mWaitReq      (mWaitReq),
    .strobe        (strobe),
    .mWrite        (mWrite),
    .intxReq       (intxReq)
  );

  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (mWrite && mWaitReq) |=> (mWrite && $stable(mAddr) && $stable(mWriteData))) // R8
    else $error("master bus changed while stalled");

endmodule

// File: tb/test_hostIrqDispatch.sv
`timescale 1ns/1ps
module test_hostIrqDispatch;

  localparam int NUM_MBOX = 8;
  localparam int ADDR_W   = 6;
  localparam int DATA_W   = 32;
  localparam logic [31:0] MSI_A = 32'hFEE0_1000;
  localparam logic [15:0] MSI_D = 16'h0042;

  // {msiEn, intxDis, mask[7:0], mbox[2:0], unused, expIntx, expMsi}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 1'b0, 8'hFF, 3'd0, 1'b0, 1'b1, 1'b0},  // R5 legacy
    {1'b0, 1'b0, 8'h00, 3'd3, 1'b0, 1'b0, 1'b0},  // R4 masked
    {1'b0, 1'b0, 8'h08, 3'd3, 1'b0, 1'b1, 1'b0},  // R4 single unmasked
    {1'b1, 1'b1, 8'hFF, 3'd5, 1'b0, 1'b0, 1'b1},  // R7 MSI
    {1'b1, 1'b0, 8'hFF, 3'd7, 1'b0, 1'b0, 1'b1},  // R9 both enabled
    {1'b0, 1'b1, 8'hFF, 3'd2, 1'b0, 1'b0, 1'b0},  // R6 silenced
    {1'b1, 1'b1, 8'hF7, 3'd3, 1'b0, 1'b0, 1'b0},  // R4 masked in MSI
    {1'b1, 1'b1, 8'h80, 3'd7, 1'b0, 1'b0, 1'b1}   // R7 top mailbox
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] sAddr = '0;
  logic              sWrite = 1'b0;
  logic [DATA_W-1:0] sWriteData = '0;
  logic [DATA_W-1:0] sReadData;
  logic              cfgIntxDisable = 1'b0;
  logic              cfgMsiEnable = 1'b0;
  logic [31:0]       mAddr;
  logic [DATA_W-1:0] mWriteData;
  logic              mWrite;
  logic              mWaitReq = 1'b0;
  logic              intxReq;

  int checks = 0;
  int fails = 0;
  int accepted = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hostIrqDispatch i_hostIrqDispatch (
    .clk(clk), .rstN(rstN), .sAddr(sAddr), .sWrite(sWrite),
    .sWriteData(sWriteData), .sReadData(sReadData),
    .cfgIntxDisable(cfgIntxDisable), .cfgMsiEnable(cfgMsiEnable),
    .msiAddr(MSI_A), .msiData(MSI_D), .mAddr(mAddr),
    .mWriteData(mWriteData), .mWrite(mWrite), .mWaitReq(mWaitReq),
    .intxReq(intxReq)
  );

  always @(posedge clk) if (rstN && mWrite && !mWaitReq) accepted <= accepted + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    sAddr = ADDR_W'(a); sWriteData = d; sWrite = 1'b1;
    tick(1);
    sWrite = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    sAddr = ADDR_W'(a);
    #0.5;
    d = sReadData;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int base;
    tick(3);
    // R1 reset state
    rd(0, r); check("R1 status", r, 0);
    rd(1, r); check("R1 mask", r, 0);
    check("R1 intxReq", 32'(intxReq), 0);
    check("R1 mWrite", 32'(mWrite), 0);
    rstN = 1'b1;
    tick(2);

    // table walk
    for (int v = 0; v < 8; v++) begin
      cfgMsiEnable   = VEC[v][15];
      cfgIntxDisable = VEC[v][14];
      wr(1, 32'(VEC[v][13:6]));
      base = accepted;
      wr(2 + int'(VEC[v][5:3]), 32'h100 + 32'(v));
      tick(1);
      check($sformatf("R5/R7 vec%0d intxReq", v), 32'(intxReq), 32'(VEC[v][1]));
      check($sformatf("R7 vec%0d mWrite", v), 32'(mWrite), 32'(VEC[v][0]));
      if (VEC[v][0]) begin
        check($sformatf("R7 vec%0d mAddr", v), mAddr, MSI_A);
        check($sformatf("R7 vec%0d mWriteData", v), mWriteData, 32'(MSI_D));
      end
      tick(2);
      check($sformatf("R7 vec%0d write count", v), 32'(accepted - base), 32'(VEC[v][0]));
      wr(0, 32'hFF);
      tick(2);
      check($sformatf("R5 vec%0d intx cleared", v), 32'(intxReq), 0);
    end

    // R2 mailbox data and status
    cfgMsiEnable = 1'b0; cfgIntxDisable = 1'b1;
    wr(6, 32'hA5A5_1234);
    rd(6, r); check("R2 mailbox data", r, 32'hA5A5_1234);
    rd(0, r); check("R2 status bit4", r, 32'h10);
    // R3 write-one-to-clear
    wr(0, 32'h01);
    rd(0, r); check("R3 zero bits kept", r, 32'h10);
    wr(0, 32'h10);
    rd(0, r); check("R3 one bits cleared", r, 0);
    wr(1, 32'hFFFF_FFFF);
    rd(1, r); check("R3 mask width", r, 32'hFF);

    // R12 unmapped address
    wr(32, 32'hDEAD_BEEF);
    rd(32, r); check("R12 unmapped read", r, 0);
    rd(0, r); check("R12 status untouched", r, 0);
    rd(1, r); check("R12 mask untouched", r, 32'hFF);

    // R5 level across partial clears
    cfgIntxDisable = 1'b0;
    wr(3, 1); wr(4, 2);
    tick(1);
    check("R5 asserted", 32'(intxReq), 1);
    wr(0, 32'h02);
    tick(1);
    check("R5 held with one left", 32'(intxReq), 1);
    wr(0, 32'h04);
    tick(1);
    check("R5 dropped after last", 32'(intxReq), 0);

    // R6 silenced then re-enabled
    cfgIntxDisable = 1'b1;
    base = accepted;
    wr(2, 7);
    tick(3);
    check("R6 no intx", 32'(intxReq), 0);
    check("R6 no write", 32'(accepted - base), 0);
    rd(0, r); check("R6 status kept", r, 32'h01);
    cfgIntxDisable = 1'b0;
    tick(1);
    check("R6 delivered later", 32'(intxReq), 1);

    // R10 legacy -> MSI -> legacy with request held
    base = accepted;
    cfgMsiEnable = 1'b1;
    tick(1);
    check("R10 MSI sent on switch", 32'(mWrite), 1);
    check("R10 intx dropped", 32'(intxReq), 0);
    tick(1);
    cfgIntxDisable = 1'b1;
    tick(3);
    check("R10 single write", 32'(accepted - base), 1);
    cfgIntxDisable = 1'b0;
    tick(2);
    check("R9 overlap no intx", 32'(intxReq), 0);
    cfgMsiEnable = 1'b0;
    tick(1);
    check("R10 intx after MSI off", 32'(intxReq), 1);
    check("R10 no extra write", 32'(accepted - base), 1);
    wr(0, 32'hFF);
    tick(2);

    // R8 stall hold
    cfgMsiEnable = 1'b1; cfgIntxDisable = 1'b1; mWaitReq = 1'b1;
    base = accepted;
    wr(2, 9);
    tick(1);
    check("R8 write raised", 32'(mWrite), 1);
    tick(3);
    check("R8 write held", 32'(mWrite), 1);
    check("R8 addr held", mAddr, MSI_A);
    mWaitReq = 1'b0;
    tick(1);
    check("R8 write dropped", 32'(mWrite), 0);
    check("R8 one accepted", 32'(accepted - base), 1);
    wr(0, 32'hFF);
    tick(2);

    // R11 re-edge while stalled
    mWaitReq = 1'b1;
    base = accepted;
    wr(2, 1);
    tick(1);
    wr(0, 32'h01);
    wr(3, 2);
    tick(1);
    mWaitReq = 1'b0;
    tick(4);
    check("R11 two writes", 32'(accepted - base), 2);
    check("R11 idle after", 32'(mWrite), 0);
    wr(0, 32'hFF);
    tick(2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule